// File: doc/BRIEF.md
# Three-Wire Configuration Register Bank for a Dual Synthesizer

This block accepts 24-bit configuration words over a three-wire serial link (serial data, serial clock and a latch strobe) and stores each word in one of a small set of addressed control registers. It sits beside the datapaths of a dual frequency synthesizer. Those datapaths take their divide counts, power-down, pump gain, fastlock timeout and test-output selection as parallel signals that this block decodes from the stored words.

The serial pins are brought into the system clock domain by two-stage synchronizers, and their edges are detected there. Each rising serial clock edge shifts one bit into a 24-bit shift register, most significant bit first. A rising latch strobe copies the whole shift register into the register named by its three lowest bits. The decoded fields are registered before they reach the ports. One field, the 4-bit output select, takes two bits from each of two different registers.

Top module: `synth_cfg_regbank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every decoded output is zero. This covers all stored registers.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` in at bit 0 of the shift register, and the older bits move one place up. After 24 edges, the first bit sent sits in word bit 23.
- R3: Word bits [2:0] select the target register. Addresses 0 to 5 are stored.
- R4: The decoded outputs take the new value on the fifth rising `clk` edge after `ser_le` goes high. On the fourth edge they still show the old value.
- R5: Register 1 supplies three outputs. `rf_swallow` comes from bits [6:3], `rf_count` from bits [21:7], and `rf_pwrdn` from bit 23.
- R6: Register 4 supplies `if_count` from bits [20:7].
- R7: Register 3 bit 19 drives `if_cp_gain`. Register 5 bits [14:3] drive the 12-bit `if_fl_timeout`, which ranges from 0 to 4095.
- R8: `out_sel` is the 4-bit concatenation {register 3 bits [23:22], register 0 bits [23:22]}.
- R9: Words addressed to 6 or 7 change no stored register and no output.
- R10: The shift register is never cleared by a transfer. A latch strobe after fewer than 24 serial clocks transfers the old contents, shifted up by the number of new bits, with the new bits at the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; its rising edge transfers the word |
| rf_swallow | output | 4 | RF swallow count |
| rf_count | output | 15 | RF binary count |
| rf_pwrdn | output | 1 | RF power-down |
| if_count | output | 14 | IF binary count |
| if_cp_gain | output | 1 | IF charge-pump gain select |
| if_fl_timeout | output | 12 | IF fastlock timeout |
| out_sel | output | 4 | Multifunction output select |

## Verification
A word's fields reach the ports five `clk` edges after `ser_le` rises. Two of those edges are spent in the synchronizer, one in the transfer register, one in the bank and one in the output register. The table-driven checks therefore wait eight cycles after the strobe falls, which is well past that point. One directed test samples at the falling `clk` edge right after the fourth and right after the fifth rising edge, so it pins the exact due cycle. Serial bits are held for three system cycles on each side of every serial clock edge, so each edge passes through the synchronizer with its data bit stable.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int WORD_W  = 24;
  localparam int ADDR_W  = 3;
  localparam int SLOTS   = 1 << ADDR_W;
  localparam int USED    = 6;

  // slot numbers
  localparam int SL_OSEL_LO = 0;
  localparam int SL_RFDIV   = 1;
  localparam int SL_IFPUMP  = 3;
  localparam int SL_IFDIV   = 4;
  localparam int SL_IFFAST  = 5;

  typedef struct packed {
    logic [3:0]  rf_swallow;
    logic [14:0] rf_count;
    logic        rf_pwrdn;
    logic [13:0] if_count;
    logic        if_cp_gain;
    logic [11:0] if_fl_timeout;
    logic [3:0]  out_sel;
  } cfg_fields_t;
endpackage

// File: rtl/ser_front.sv
module ser_front #(
  parameter int WORD_W = 24,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int LINES = 3;

  logic [LINES-1:0] sync_q [SYNC_N];
  logic [LINES-1:0] s_now, s_prev;
  logic             clk_rise, le_rise;
  logic [WORD_W-1:0] sr;

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= '0;
        else if (g == 0) sync_q[g] <= {ser_le, ser_dat, ser_clk};
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign s_now = sync_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) s_prev <= '0;
    else     s_prev <= s_now;
  end

  assign clk_rise = s_now[0] & ~s_prev[0];
  assign le_rise  = s_now[2] & ~s_prev[2];

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (clk_rise) sr <= {sr[WORD_W-2:0], s_now[1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= le_rise;
      if (le_rise) word <= sr;
    end
  end

  // R2: a detected serial edge places the synchronized data bit at the bottom
  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    clk_rise |=> sr[0] == $past(s_now[1]));

  // R4: one transfer per strobe edge
  p_le_single_r4: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3,
  parameter int USED   = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_vld,
  input  logic [WORD_W-1:0]                  wr_word,
  output logic [(1<<ADDR_W)-1:0][WORD_W-1:0] slots
);
  localparam int SLOTS = 1 << ADDR_W;

  logic [ADDR_W-1:0] wr_addr;
  assign wr_addr = wr_word[ADDR_W-1:0];

  genvar i;
  generate
    for (i = 0; i < SLOTS; i++) begin : g_slot
      if (i < USED) begin : g_store
        always_ff @(posedge clk) begin
          if (rst) slots[i] <= '0;
          else if (wr_vld && wr_addr == ADDR_W'(i)) slots[i] <= wr_word;
        end

        // R3: an addressed word lands in its own slot
        p_slot_write_r3: assert property (@(posedge clk) disable iff (rst)
          (wr_vld && wr_addr == ADDR_W'(i)) |=> slots[i] == $past(wr_word));
      end else begin : g_empty
        assign slots[i] = '0;
      end
    end
  endgenerate

  // R9: writes to unused addresses leave the bank untouched
  p_unused_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && int'(wr_addr) >= USED) |=> slots == $past(slots));
endmodule

// File: rtl/field_map.sv
module field_map
  import sercfg_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [(1<<ADDR_W)-1:0][WORD_W-1:0] slots,
  output cfg_fields_t                        fields
);
  cfg_fields_t nxt;
  logic        unused_slots;

  assign unused_slots = ^slots;

  always_comb begin
    nxt               = '0;
    nxt.rf_swallow    = slots[SL_RFDIV][6:3];
    nxt.rf_count      = slots[SL_RFDIV][21:7];
    nxt.rf_pwrdn      = slots[SL_RFDIV][23];
    nxt.if_count      = slots[SL_IFDIV][20:7];
    nxt.if_cp_gain    = slots[SL_IFPUMP][19];
    nxt.if_fl_timeout = slots[SL_IFFAST][14:3];
    nxt.out_sel       = {slots[SL_IFPUMP][23:22], slots[SL_OSEL_LO][23:22]};
  end

  always_ff @(posedge clk) begin
    if (rst) fields <= '0;
    else     fields <= nxt;
  end

  // R8: select field split across two slots, one cycle behind the bank
  p_outsel_split_r8: assert property (@(posedge clk) disable iff (rst)
    fields.out_sel == {$past(slots[SL_IFPUMP][23:22]), $past(slots[SL_OSEL_LO][23:22])});

  // R1: cleared fields right after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> fields == '0);
endmodule

// File: rtl/synth_cfg_regbank.sv
module synth_cfg_regbank
  import sercfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_le,
  output logic [3:0]  rf_swallow,
  output logic [14:0] rf_count,
  output logic        rf_pwrdn,
  output logic [13:0] if_count,
  output logic        if_cp_gain,
  output logic [11:0] if_fl_timeout,
  output logic [3:0]  out_sel
);
  logic                         word_vld;
  logic [WORD_W-1:0]            word;
  logic [SLOTS-1:0][WORD_W-1:0] slots;
  cfg_fields_t                  fields;

  ser_front #(.WORD_W(WORD_W), .SYNC_N(2)) front_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_le(ser_le), .word_vld(word_vld), .word(word)
  );

  reg_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .USED(USED)) bank_i (
    .clk(clk), .rst(rst), .wr_vld(word_vld), .wr_word(word), .slots(slots)
  );

  field_map #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) map_i (
    .clk(clk), .rst(rst), .slots(slots), .fields(fields)
  );

  assign rf_swallow    = fields.rf_swallow;
  assign rf_count      = fields.rf_count;
  assign rf_pwrdn      = fields.rf_pwrdn;
  assign if_count      = fields.if_count;
  assign if_cp_gain    = fields.if_cp_gain;
  assign if_fl_timeout = fields.if_fl_timeout;
  assign out_sel       = fields.out_sel;
endmodule

// File: tb/synth_cfg_regbank_tb.sv
module synth_cfg_regbank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [3:0]  rf_swallow;
  logic [14:0] rf_count;
  logic        rf_pwrdn;
  logic [13:0] if_count;
  logic        if_cp_gain;
  logic [11:0] if_fl_timeout;
  logic [3:0]  out_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_cfg_regbank dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .rf_swallow(rf_swallow), .rf_count(rf_count), .rf_pwrdn(rf_pwrdn),
    .if_count(if_count), .if_cp_gain(if_cp_gain),
    .if_fl_timeout(if_fl_timeout), .out_sel(out_sel)
  );

  // field ids: 0 rf_swallow 1 rf_count 2 rf_pwrdn 3 if_count 4 if_cp_gain 5 if_fl_timeout 6 out_sel
  localparam int NV = 10;
  localparam logic [23:0] V_WORD [NV] = '{
    24'h891A51, 24'h891A51, 24'h891A51, 24'h155E04, 24'h880003,
    24'h400000, 24'h007F6D, 24'hFFFFFE, 24'hFFFFFF, 24'h3FFF81};
  localparam int V_FLD [NV] = '{0, 1, 2, 3, 4, 6, 5, 6, 1, 1};
  localparam logic [15:0] V_EXP [NV] = '{
    16'h000A, 16'h1234, 16'h0001, 16'h2ABC, 16'h0001,
    16'h0009, 16'h0FED, 16'h0009, 16'h1234, 16'h7FFF};
  localparam string V_REQ [NV] = '{"R5", "R5", "R5", "R6", "R7",
                                   "R8", "R7", "R9", "R9", "R3"};

  function automatic logic [15:0] get_field(int id);
    case (id)
      0: return 16'(rf_swallow);
      1: return 16'(rf_count);
      2: return 16'(rf_pwrdn);
      3: return 16'(if_count);
      4: return 16'(if_cp_gain);
      5: return 16'(if_fl_timeout);
      default: return 16'(out_sel);
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bits(logic [23:0] w, int n);
    for (int b = n - 1; b >= 0; b--) begin
      ser_dat = w[b];
      wait_clks(3);
      ser_clk = 1'b1;
      wait_clks(3);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    ser_le = 1'b1;
    wait_clks(3);
    @(negedge clk);
    ser_le = 1'b0;
  endtask

  task automatic load(logic [23:0] w);
    send_bits(w, 24);
    strobe();
    wait_clks(8);
    @(negedge clk);
  endtask

  task automatic all_zero(string req);
    check(req, {rf_swallow, rf_count[11:0]}, 16'h0);
    check(req, {rf_pwrdn, if_cp_gain, if_count}, 16'h0);
    check(req, {if_fl_timeout, out_sel}, 16'h0);
  endtask

  initial begin
    wait_clks(4);
    @(negedge clk);
    all_zero("R1");
    rst = 1'b0;
    @(negedge clk);
    all_zero("R1");

    for (int k = 0; k < NV; k++) begin
      load(V_WORD[k]);
      check(V_REQ[k], get_field(V_FLD[k]), V_EXP[k]);
    end
    // R2: shift register ends with 0x3FFF81 loaded MSB first
    check("R2", {rf_pwrdn, rf_count}, 16'h7FFF);

    // R4: exact due cycle; R1 slot swallow 5, count 0x7FFF kept
    send_bits(24'h3FFFA9, 24);
    @(negedge clk);
    ser_le = 1'b1;
    wait_clks(4);
    @(negedge clk);
    check("R4", 16'(rf_swallow), 16'h0);
    wait_clks(1);
    @(negedge clk);
    check("R4", 16'(rf_swallow), 16'h5);
    ser_le = 1'b0;
    wait_clks(4);

    // R10: partial word of three bits 011 after 0x3FFFA9 -> 0xFFFD4B to slot 3
    send_bits(24'h000003, 3);
    strobe();
    wait_clks(8);
    @(negedge clk);
    check("R10", 16'(out_sel), 16'h000D);
    check("R10", 16'(if_cp_gain), 16'h1);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    wait_clks(2);
    @(negedge clk);
    all_zero("R1");
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clks(150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule